// File: doc/BRIEF.md
# Event Priority and Vector Unit

This unit sits next to a small 32-bit processor pipeline and decides, every clock cycle, which of six pending control-flow events the pipeline must take. The candidates are a reset request, a hardware exception, a non-maskable break, a maskable break, an interrupt and a user (software) exception. Interrupt and maskable-break requests are first qualified against the status bits. The highest-ranked survivor is then turned into a redirect target, a return-address destination and a one-cycle accept pulse.

Targets are formed from a parameterised vector base plus a fixed per-class slot offset. Slots are 8 bytes apart, so an immediate-prefix and absolute-branch pair fits in each one. In low-latency mode the interrupt target is taken from an external vector input instead. The unit also holds the reservation flag used by exclusive load/store sequences. It clears that flag on every accepted event.

Request lines are level-held by their sources. The unit does not consume them. A request that loses arbitration stays visible and is taken later, once the source still asserts it.

Top module: `evt_vec_unit`

## Requirements
- R1: Among qualified requests the winner follows the order reset > hardware exception > non-maskable break > maskable break > interrupt > user exception. `evt_o` reports the accepted class as 1 reset, 2 hardware exception, 3 non-maskable break, 4 maskable break, 5 interrupt, 6 user exception, and 0 in any cycle without an accept.
- R2: An interrupt request qualifies only when `irq_en_i` is 1 and both `brk_act_i` and `exc_act_i` are 0. A maskable break is dropped while `brk_act_i` is 1. Non-maskable break, hardware exception, user exception and reset requests ignore all three bits.
- R3: On accept, `target_o` equals BASE plus the class offset: 0x00 for reset, 0x08 for user exception, 0x10 for interrupt, 0x18 for either break, and 0x20 for hardware exception.
- R4: When `lowlat_i` is 1, an accepted interrupt takes `target_o` from `ext_vec_i`. The other classes are unaffected.
- R5: On accept, `ret_reg_o` is 14 for an interrupt, 16 for either break, 17 for a hardware exception, and `usr_rd_i` for a user exception. `ret_we_o` is 1 for these classes and 0 for reset.
- R6: For a hardware exception with `delay_slot_i` at 1, `btr_we_o` is 1 and `ret_we_o` is 0. `btr_we_o` is 0 for every other case.
- R7: `resv_o` goes to 1 the cycle after `resv_set_i` is sampled at 1. It goes to 0 in the same cycle that `accept_o` is 1. If both happen together, the clear wins.
- R8: Inputs sampled at a clock edge appear on the outputs right after that edge. `accept_o` is never 1 in two consecutive cycles. A request still held after a holdoff cycle is accepted on the next edge.
- R9: While `rst_ni` is 0, `accept_o`, `ret_we_o`, `btr_we_o` and `resv_o` are 0, `evt_o` is 0 and `target_o` equals BASE.
- R10: Apart from a low-latency interrupt vector, `target_o` on accept never falls in BASE+0x28 through BASE+0x4F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_rst_i | input | 1 | Reset event request |
| req_hwexc_i | input | 1 | Hardware exception request |
| req_nmbrk_i | input | 1 | Non-maskable break request |
| req_brk_i | input | 1 | Maskable break request |
| req_irq_i | input | 1 | Interrupt request |
| req_usrexc_i | input | 1 | User exception request |
| irq_en_i | input | 1 | Interrupt enable status bit |
| brk_act_i | input | 1 | A break is in progress |
| exc_act_i | input | 1 | An exception is in progress |
| delay_slot_i | input | 1 | Hardware fault sits in a branch delay slot |
| usr_rd_i | input | REGW | Return register named by the user-exception instruction |
| lowlat_i | input | 1 | Low-latency interrupt mode select |
| ext_vec_i | input | XLEN | Interrupt vector from the external controller |
| resv_set_i | input | 1 | Exclusive load sets the reservation |
| accept_o | output | 1 | One-cycle event accept |
| evt_o | output | 3 | Accepted event class code |
| target_o | output | XLEN | Redirect address |
| ret_we_o | output | 1 | Write return address to the register file |
| ret_reg_o | output | REGW | Register-file index for the return address |
| btr_we_o | output | 1 | Write return address to the branch-target register |
| resv_o | output | 1 | Reservation flag |

## Verification
Every one of the 64 request subsets is combined with all 32 settings of the three mask bits, the low-latency select and the delay-slot flag. This separates a mis-ordered priority chain from a wrong mask gate. A subset whose top request is masked must fall through to the next one, and that only happens if both the order and the gating are right. An idle cycle is placed between events. Separate directed runs hold overlapping requests over several cycles to show the holdoff and that the loser is picked up afterwards. They also interleave reservation sets with accepts to show which update wins. A non-zero base is used so that a missing base term in the target shows up as a mismatch.

// File: rtl/evt_vec_pkg.sv
package evt_vec_pkg;

  localparam int unsigned NUM_EVT    = 6;
  localparam int unsigned SLOT_SHIFT = 3;  // 8-byte slots

  // priority index, 0 = highest
  localparam int unsigned P_RST   = 0;
  localparam int unsigned P_HWEXC = 1;
  localparam int unsigned P_NMBRK = 2;
  localparam int unsigned P_BRK   = 3;
  localparam int unsigned P_IRQ   = 4;
  localparam int unsigned P_USR   = 5;

  localparam int unsigned RA_IRQ   = 14;
  localparam int unsigned RA_BRK   = 16;
  localparam int unsigned RA_HWEXC = 17;

  typedef enum logic [2:0] {
    EVT_NONE   = 3'd0,
    EVT_RESET  = 3'd1,
    EVT_HWEXC  = 3'd2,
    EVT_NMBRK  = 3'd3,
    EVT_BRK    = 3'd4,
    EVT_IRQ    = 3'd5,
    EVT_USREXC = 3'd6
  } evt_e;

  // slot number within the vector table
  function automatic logic [2:0] slot_of(evt_e e);
    case (e)
      EVT_USREXC:        slot_of = 3'd1;
      EVT_IRQ:           slot_of = 3'd2;
      EVT_NMBRK, EVT_BRK: slot_of = 3'd3;
      EVT_HWEXC:         slot_of = 3'd4;
      default:           slot_of = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/evt_qualify.sv
module evt_qualify
  import evt_vec_pkg::*;
#(
  parameter int unsigned N = NUM_EVT
) (
  input  logic [N-1:0] req_i,
  input  logic         irq_en_i,
  input  logic         brk_act_i,
  input  logic         exc_act_i,
  output logic [N-1:0] qual_o
);

  logic irq_ok;
  assign irq_ok = irq_en_i & ~brk_act_i & ~exc_act_i;

  always_comb begin
    qual_o = req_i;
    if (!irq_ok)  qual_o[P_IRQ] = 1'b0;
    if (brk_act_i) qual_o[P_BRK] = 1'b0;
  end

endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
  parameter int unsigned N    = 6,
  localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    win_oh_o,
  output logic [IDXW-1:0] win_idx_o,
  output logic            any_o
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign win_oh_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]    = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    win_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (win_oh_o[i]) win_idx_o = win_idx_o | IDXW'(i);
    end
  end

endmodule

// File: rtl/evt_vector_map.sv
module evt_vector_map
  import evt_vec_pkg::*;
#(
  parameter int unsigned     XLEN = 32,
  parameter int unsigned     REGW = 5,
  parameter logic [XLEN-1:0] BASE = '0
) (
  input  evt_e            evt_i,
  input  logic            lowlat_i,
  input  logic [XLEN-1:0] ext_vec_i,
  input  logic            delay_slot_i,
  input  logic [REGW-1:0] usr_rd_i,
  output logic [XLEN-1:0] target_o,
  output logic            ret_we_o,
  output logic [REGW-1:0] ret_reg_o,
  output logic            btr_we_o
);

  always_comb begin
    if (evt_i == EVT_IRQ && lowlat_i) target_o = ext_vec_i;
    else target_o = BASE + (XLEN'(slot_of(evt_i)) << SLOT_SHIFT);
  end

  always_comb begin
    ret_we_o  = 1'b1;
    btr_we_o  = 1'b0;
    ret_reg_o = '0;
    case (evt_i)
      EVT_IRQ:            ret_reg_o = REGW'(RA_IRQ);
      EVT_NMBRK, EVT_BRK: ret_reg_o = REGW'(RA_BRK);
      EVT_USREXC:         ret_reg_o = usr_rd_i;
      EVT_HWEXC: begin
        ret_reg_o = REGW'(RA_HWEXC);
        ret_we_o  = ~delay_slot_i;
        btr_we_o  = delay_slot_i;
      end
      default:            ret_we_o  = 1'b0;
    endcase
  end

endmodule

// File: rtl/evt_vec_unit.sv
module evt_vec_unit
  import evt_vec_pkg::*;
#(
  parameter int unsigned     XLEN = 32,
  parameter int unsigned     REGW = 5,
  parameter logic [XLEN-1:0] BASE = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_rst_i,
  input  logic            req_hwexc_i,
  input  logic            req_nmbrk_i,
  input  logic            req_brk_i,
  input  logic            req_irq_i,
  input  logic            req_usrexc_i,
  input  logic            irq_en_i,
  input  logic            brk_act_i,
  input  logic            exc_act_i,
  input  logic            delay_slot_i,
  input  logic [REGW-1:0] usr_rd_i,
  input  logic            lowlat_i,
  input  logic [XLEN-1:0] ext_vec_i,
  input  logic            resv_set_i,
  output logic            accept_o,
  output logic [2:0]      evt_o,
  output logic [XLEN-1:0] target_o,
  output logic            ret_we_o,
  output logic [REGW-1:0] ret_reg_o,
  output logic            btr_we_o,
  output logic            resv_o
);

  localparam int unsigned IDXW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [NUM_EVT-1:0] req_vec, qual, win_oh;
  logic [IDXW-1:0]    win_idx;
  logic               any_win, grant;
  evt_e               win_evt;
  logic [XLEN-1:0]    nxt_target;
  logic               nxt_ret_we, nxt_btr_we;
  logic [REGW-1:0]    nxt_ret_reg;

  always_comb begin
    req_vec          = '0;
    req_vec[P_RST]   = req_rst_i;
    req_vec[P_HWEXC] = req_hwexc_i;
    req_vec[P_NMBRK] = req_nmbrk_i;
    req_vec[P_BRK]   = req_brk_i;
    req_vec[P_IRQ]   = req_irq_i;
    req_vec[P_USR]   = req_usrexc_i;
  end

  evt_qualify #(.N(NUM_EVT)) u_qual (
    .req_i     (req_vec),
    .irq_en_i  (irq_en_i),
    .brk_act_i (brk_act_i),
    .exc_act_i (exc_act_i),
    .qual_o    (qual)
  );

  evt_prio_pick #(.N(NUM_EVT)) u_pick (
    .req_i     (qual),
    .win_oh_o  (win_oh),
    .win_idx_o (win_idx),
    .any_o     (any_win)
  );

  assign win_evt = any_win ? evt_e'(3'(win_idx) + 3'd1) : EVT_NONE;

  evt_vector_map #(.XLEN(XLEN), .REGW(REGW), .BASE(BASE)) u_map (
    .evt_i        (win_evt),
    .lowlat_i     (lowlat_i),
    .ext_vec_i    (ext_vec_i),
    .delay_slot_i (delay_slot_i),
    .usr_rd_i     (usr_rd_i),
    .target_o     (nxt_target),
    .ret_we_o     (nxt_ret_we),
    .ret_reg_o    (nxt_ret_reg),
    .btr_we_o     (nxt_btr_we)
  );

  // one redirect bubble after each accept
  assign grant = any_win & ~accept_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      evt_o     <= EVT_NONE;
      target_o  <= BASE;
      ret_we_o  <= 1'b0;
      ret_reg_o <= '0;
      btr_we_o  <= 1'b0;
    end else begin
      accept_o <= grant;
      evt_o    <= grant ? win_evt : EVT_NONE;
      ret_we_o <= grant & nxt_ret_we;
      btr_we_o <= grant & nxt_btr_we;
      if (grant) begin
        target_o  <= nxt_target;
        ret_reg_o <= nxt_ret_reg;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         resv_o <= 1'b0;
    else if (grant)      resv_o <= 1'b0;
    else if (resv_set_i) resv_o <= 1'b1;
  end

endmodule

// File: rtl/evt_vec_chk.sv
module evt_vec_chk
  import evt_vec_pkg::*;
#(
  parameter int unsigned     XLEN = 32,
  parameter logic [XLEN-1:0] BASE = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            accept_o,
  input logic [2:0]      evt_o,
  input logic [XLEN-1:0] target_o,
  input logic            ret_we_o,
  input logic            btr_we_o,
  input logic            resv_o,
  input logic            irq_en_i,
  input logic            brk_act_i,
  input logic            exc_act_i,
  input logic [NUM_EVT-1:0] win_oh
);

  logic [XLEN-1:0] off;
  assign off = target_o - BASE;

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);

  assert_resv_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !resv_o);

  assert_reset_noret_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && evt_o == EVT_RESET) |-> (!ret_we_o && !btr_we_o));

  assert_irq_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && evt_o == EVT_IRQ) |-> $past(irq_en_i && !brk_act_i && !exc_act_i));

  assert_onehot_win_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_oh));

  assert_no_reserved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && evt_o != EVT_IRQ) |-> !(off >= XLEN'(32'h28) && off <= XLEN'(32'h4F)));

  assert_hwexc_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && evt_o == EVT_HWEXC) |-> (off == XLEN'(32'h20)));

  assert_we_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ret_we_o && btr_we_o));

endmodule

bind evt_vec_unit evt_vec_chk #(.XLEN(XLEN), .BASE(BASE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .accept_o  (accept_o),
  .evt_o     (evt_o),
  .target_o  (target_o),
  .ret_we_o  (ret_we_o),
  .btr_we_o  (btr_we_o),
  .resv_o    (resv_o),
  .irq_en_i  (irq_en_i),
  .brk_act_i (brk_act_i),
  .exc_act_i (exc_act_i),
  .win_oh    (win_oh)
);

// File: tb/evt_vec_unit_tb.sv
module evt_vec_unit_tb;

  localparam logic [31:0] TB_BASE = 32'h0001_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_rst_i = 0, req_hwexc_i = 0, req_nmbrk_i = 0, req_brk_i = 0;
  logic        req_irq_i = 0, req_usrexc_i = 0;
  logic        irq_en_i = 0, brk_act_i = 0, exc_act_i = 0, delay_slot_i = 0;
  logic [4:0]  usr_rd_i = '0;
  logic        lowlat_i = 0;
  logic [31:0] ext_vec_i = '0;
  logic        resv_set_i = 0;
  logic        accept_o;
  logic [2:0]  evt_o;
  logic [31:0] target_o;
  logic        ret_we_o;
  logic [4:0]  ret_reg_o;
  logic        btr_we_o;
  logic        resv_o;

  evt_vec_unit #(.XLEN(32), .REGW(5), .BASE(TB_BASE)) u_dut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  typedef struct {
    bit          acc;
    logic [2:0]  evt;
    logic [31:0] tgt;
    bit          we;
    logic [4:0]  rr;
    bit          btr;
    bit          resv;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, fails = 0;
  bit   m_prev_acc = 0, m_resv = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model, computed from the requirements
  task automatic drive(input logic [5:0] req, input logic [4:0] ctl,
                       input logic [4:0] rd, input logic [31:0] ev,
                       input bit rset, input string tag);
    exp_t e;
    logic [5:0] qv;
    int w;
    @(negedge clk_i);
    {req_usrexc_i, req_irq_i, req_brk_i, req_nmbrk_i, req_hwexc_i, req_rst_i} = req;
    {delay_slot_i, lowlat_i, exc_act_i, brk_act_i, irq_en_i} = ctl;
    usr_rd_i = rd; ext_vec_i = ev; resv_set_i = rset;
    qv = req;
    if (!(ctl[0] && !ctl[1] && !ctl[2])) qv[4] = 1'b0;
    if (ctl[1]) qv[3] = 1'b0;
    w = -1;
    for (int i = 5; i >= 0; i--) if (qv[i]) w = i;
    e.acc = (w >= 0) && !m_prev_acc;
    e.evt = e.acc ? 3'(w + 1) : 3'd0;
    e.we = 0; e.btr = 0; e.rr = 0; e.tgt = TB_BASE;
    case (e.evt)
      3'd1: e.tgt = TB_BASE;
      3'd2: begin e.tgt = TB_BASE + 32'h20; e.rr = 5'd17; e.we = !ctl[4]; e.btr = ctl[4]; end
      3'd3, 3'd4: begin e.tgt = TB_BASE + 32'h18; e.rr = 5'd16; e.we = 1; end
      3'd5: begin e.tgt = ctl[3] ? ev : TB_BASE + 32'h10; e.rr = 5'd14; e.we = 1; end
      3'd6: begin e.tgt = TB_BASE + 32'h08; e.rr = rd; e.we = 1; end
      default: ;
    endcase
    m_prev_acc = e.acc;
    m_resv = e.acc ? 1'b0 : (rset ? 1'b1 : m_resv);
    e.resv = m_resv;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    drive(6'b0, 5'b0, 5'd0, 32'h0, 1'b0, "R8");
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (rst_ni && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(accept_o == e.acc && evt_o == e.evt, e.tag, "accept/evt",
            {27'd0, accept_o, 1'b0, evt_o}, {27'd0, e.acc, 1'b0, e.evt});
        chk(resv_o == e.resv, "R7", "resv", {31'd0, resv_o}, {31'd0, e.resv});
        chk(ret_we_o == e.we && btr_we_o == e.btr, "R6", "we/btr",
            {30'd0, ret_we_o, btr_we_o}, {30'd0, e.we, e.btr});
        if (e.acc) begin
          chk(target_o == e.tgt, (e.evt == 3'd5) ? "R4" : "R3", "target", target_o, e.tgt);
          if (e.evt != 3'd1)
            chk(ret_reg_o == e.rr, "R5", "ret_reg", {27'd0, ret_reg_o}, {27'd0, e.rr});
          if (e.evt != 3'd5)
            chk(!((target_o - TB_BASE) >= 32'h28 && (target_o - TB_BASE) <= 32'h4F),
                "R10", "reserved slot", target_o, e.tgt);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!accept_o && evt_o == 3'd0 && !ret_we_o && !btr_we_o && !resv_o, "R9", "reset ctl",
        {25'd0, accept_o, evt_o, ret_we_o, btr_we_o, resv_o}, 32'd0);
    chk(target_o == TB_BASE, "R9", "reset target", target_o, TB_BASE);
    rst_ni = 1'b1;

    // R1/R2 exhaustive: all request subsets x mask/mode settings
    for (int v = 0; v < 64; v++) begin
      for (int c = 0; c < 32; c++) begin
        drive(6'(v), 5'(c), 5'(v ^ (c << 1)), 32'hA500_0000 | 32'(v << 4), c[0], "R1/R2");
        idle();
      end
    end

    // R8 holdoff and pick-up of the loser: irq + usrexc held
    drive(6'b110000, 5'b00001, 5'd9, 32'h0, 1'b0, "R8");
    drive(6'b110000, 5'b00001, 5'd9, 32'h0, 1'b0, "R8");
    drive(6'b100000, 5'b00001, 5'd9, 32'h0, 1'b0, "R8");
    idle();
    // R4 low-latency interrupt
    drive(6'b010000, 5'b01001, 5'd0, 32'hDEAD_BEE0, 1'b0, "R4");
    idle();
    // R6 hw exception in delay slot
    drive(6'b000010, 5'b10000, 5'd0, 32'h0, 1'b0, "R6");
    idle();
    // R7 reservation set, hold, cleared by event together with set
    drive(6'b0, 5'b0, 5'd0, 32'h0, 1'b1, "R7");
    idle();
    drive(6'b100000, 5'b0, 5'd3, 32'h0, 1'b1, "R7");
    idle();
    // R2 masked-only requests produce nothing
    drive(6'b011000, 5'b00010, 5'd0, 32'h0, 1'b0, "R2");
    idle();
    // R1 reset request beats everything, R5 no return write
    drive(6'b111111, 5'b00001, 5'd7, 32'h0, 1'b1, "R1");
    idle();

    @(negedge clk_i);
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule